// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed 16-bit operands and adds the product into a 42-bit signed accumulator. The accumulator is visible as two read ports: a 10-bit upper part and a 32-bit lower part. A command set drives it. A clear command zeroes the accumulator. A load command writes either part from a 32-bit data port. An accumulate strobe adds the product of the two operand ports. The upper and lower parts can be read at any time.

A mode input selects between two kinds of accumulate. In saturating mode the sum is clamped to the signed 32-bit range. In wrapping mode the full 42-bit width is kept, and the sum wraps modulo 2^42 when it leaves that range. Three flags follow every accumulate: negative, zero and a sticky overflow. Their rules depend on the mode that is in force when the accumulate runs. Each command takes effect at the next rising clock edge, so every result is registered and visible one cycle after its command.

Top module: `mac_sat_unit`

## Requirements
- R1: A clear command (`clr`=1) sets `mac_hi` and `mac_lo` to zero and clears `flag_v` one cycle later. `flag_n` and `flag_z` keep their values.
- R2: An accumulate (`acc_valid`=1) adds the signed product `op_a`×`op_b`, sign-extended to 42 bits, to the accumulator {`mac_hi`,`mac_lo`}. The result is visible one cycle later.
- R3: In saturating mode (`sat_mode`=1), a sum above 0x7FFFFFFF is stored as 0x7FFFFFFF and a sum below -2^31 is stored as 0x80000000. In both cases `mac_hi` holds the sign extension of bit 31 and `flag_v` is set.
- R4: In wrapping mode (`sat_mode`=0), a sum outside -2^41 to 2^41-1 is stored as its low 42 bits and `flag_v` is set.
- R5: `flag_v` is sticky. An accumulate whose result is in range leaves it set. Only a clear or a load resets it.
- R6: In saturating mode an accumulate sets `flag_z` exactly when the resulting `mac_lo` is zero, whatever `mac_hi` holds.
- R7: In wrapping mode an accumulate sets `flag_z` only when both `mac_hi` and `mac_lo` are zero afterwards.
- R8: An accumulate sets `flag_n` from bit 31 of the result in saturating mode and from bit 41 in wrapping mode.
- R9: Changing `sat_mode` alone does not alter `mac_hi`, `mac_lo` or any flag.
- R10: `load_hi` writes `load_data[9:0]` to `mac_hi`. `load_lo` writes `load_data` to `mac_lo`. The two may be asserted together. A load clears `flag_v` and leaves `flag_n` and `flag_z` unchanged.
- R11: Priority is clear first, then load, then accumulate. A lower-priority command issued in the same cycle as a higher one is ignored.
- R12: With `rst_n` low at a clock edge, the accumulator and all flags are zero one cycle later.
- R13: With no command asserted, changes on `op_a`, `op_b` and `load_data` leave the accumulator and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sat_mode | input | 1 | 1 = saturating accumulate, 0 = wrapping 42-bit accumulate |
| clr | input | 1 | Clear accumulator and overflow flag |
| load_hi | input | 1 | Write upper accumulator part from load_data[9:0] |
| load_lo | input | 1 | Write lower accumulator part from load_data |
| load_data | input | 32 | Load value |
| acc_valid | input | 1 | Accumulate strobe |
| op_a | input | 16 | Signed multiplicand |
| op_b | input | 16 | Signed multiplier |
| mac_hi | output | 10 | Accumulator bits 41:32 |
| mac_lo | output | 32 | Accumulator bits 31:0 |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Sticky overflow flag |

## Verification
Every command (clear, load, accumulate or reset) is captured at one rising edge. Its effect on `mac_hi`, `mac_lo` and all three flags is due at that edge and must be stable by the following falling edge. The bench drives inputs on the falling edge and advances its behavioural model right after the rising edge. It then compares all five outputs at the next falling edge, so every command is checked exactly one cycle after it was issued. Directed sequences place the accumulator just inside each range limit, using loads, so that clamping, wrapping, sticky overflow and both zero-flag rules are reached within one step. A long mixed random stream follows.

// File: rtl/mac_pkg.sv
// Package: shared widths and the result record passed from the
// next-state logic to the top-level registers.
// Assumes: the accumulator is at least as wide as the product.
package mac_pkg;
    localparam int OP_W  = 16;
    localparam int HI_W  = 10;
    localparam int LO_W  = 32;
    localparam int ACC_W = HI_W + LO_W;
    localparam int PRD_W = 2 * OP_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
        logic             neg;
        logic             zero;
    } mac_res_t;
endpackage

// File: rtl/mac_mult.sv
// Module: signed multiplier, purely combinational.
// Assumes: both operands are two's complement; the product is full width.
module mac_mult #(
    parameter int OP_W = 16,
    localparam int PRD_W = 2 * OP_W
) (
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    output logic [PRD_W-1:0] prod_o
);
    // Full-width signed product.
    always_comb begin
        prod_o = PRD_W'($signed(a_i) * $signed(b_i));
    end
endmodule

// File: rtl/mac_next.sv
// Module: computes the accumulate sum and its overflow, then picks
// the clamped (saturating) or wrapped result.
// Assumes: PRD_W < ACC_W, and LO_W < ACC_W so that a clamp fits.
module mac_next #(
    parameter int ACC_W = 42,
    parameter int LO_W  = 32,
    parameter int PRD_W = 32,
    localparam int SUM_W = ACC_W + 1
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [PRD_W-1:0] prod_i,
    input  logic             sat_i,
    output logic [ACC_W-1:0] acc_o,
    output logic             ovf_o
);
    localparam logic signed [SUM_W-1:0] SAT_MAX =
        {{(SUM_W-LO_W+1){1'b0}}, {(LO_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SAT_MIN =
        {{(SUM_W-LO_W+1){1'b1}}, {(LO_W-1){1'b0}}};

    logic signed [SUM_W-1:0] sum;
    logic                    above, below, wrap_ovf;

    // Extended-width sum so that no overflow is lost.
    always_comb begin
        sum = $signed({acc_i[ACC_W-1], acc_i})
            + $signed({{(SUM_W-PRD_W){prod_i[PRD_W-1]}}, prod_i});
    end

    // Range tests for both modes.
    always_comb begin
        above    = (sum > SAT_MAX);
        below    = (sum < SAT_MIN);
        wrap_ovf = (sum[SUM_W-1] != sum[SUM_W-2]);
    end

    // Result selection: clamp in saturating mode, wrap otherwise.
    always_comb begin
        if (sat_i) begin
            ovf_o = above | below;
            if (above)      acc_o = SAT_MAX[ACC_W-1:0];
            else if (below) acc_o = SAT_MIN[ACC_W-1:0];
            else            acc_o = sum[ACC_W-1:0];
        end else begin
            ovf_o = wrap_ovf;
            acc_o = sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/mac_flags.sv
// Module: derives the negative and zero flags of an accumulate result
// from the rule of the active mode.
// Assumes: res_i is already clamped or wrapped.
module mac_flags #(
    parameter int ACC_W = 42,
    parameter int LO_W  = 32
) (
    input  logic [ACC_W-1:0] res_i,
    input  logic             sat_i,
    output logic             neg_o,
    output logic             zero_o
);
    // Saturating mode looks at the low word only; wrapping at all bits.
    always_comb begin
        if (sat_i) begin
            neg_o  = res_i[LO_W-1];
            zero_o = (res_i[LO_W-1:0] == '0);
        end else begin
            neg_o  = res_i[ACC_W-1];
            zero_o = (res_i == '0);
        end
    end
endmodule

// File: rtl/mac_sat_unit.sv
// Module: top of the multiply-accumulate unit. It holds the accumulator and
// the three flags, and applies commands in the order clear, load, accumulate.
// Assumes: commands are single-cycle strobes sampled on the rising edge.
module mac_sat_unit
    import mac_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sat_mode,
    input  logic            clr,
    input  logic            load_hi,
    input  logic            load_lo,
    input  logic [LO_W-1:0] load_data,
    input  logic            acc_valid,
    input  logic [OP_W-1:0] op_a,
    input  logic [OP_W-1:0] op_b,
    output logic [HI_W-1:0] mac_hi,
    output logic [LO_W-1:0] mac_lo,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_v
);
    logic [ACC_W-1:0] acc_q;
    logic             n_q, z_q, v_q;
    logic [PRD_W-1:0] prod;
    mac_res_t         nxt;
    logic             any_load;

    mac_mult #(.OP_W(OP_W)) u_mult (
        .a_i    (op_a),
        .b_i    (op_b),
        .prod_o (prod)
    );

    mac_next #(.ACC_W(ACC_W), .LO_W(LO_W), .PRD_W(PRD_W)) u_next (
        .acc_i  (acc_q),
        .prod_i (prod),
        .sat_i  (sat_mode),
        .acc_o  (nxt.acc),
        .ovf_o  (nxt.ovf)
    );

    mac_flags #(.ACC_W(ACC_W), .LO_W(LO_W)) u_flags (
        .res_i  (nxt.acc),
        .sat_i  (sat_mode),
        .neg_o  (nxt.neg),
        .zero_o (nxt.zero)
    );

    // Either half being written counts as a load.
    always_comb any_load = load_hi | load_lo;

    // Accumulator and flag registers with command priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            n_q   <= 1'b0;
            z_q   <= 1'b0;
            v_q   <= 1'b0;
        end else if (clr) begin
            acc_q <= '0;
            v_q   <= 1'b0;
        end else if (any_load) begin
            if (load_hi) acc_q[ACC_W-1:LO_W] <= load_data[HI_W-1:0];
            if (load_lo) acc_q[LO_W-1:0]     <= load_data;
            v_q <= 1'b0;
        end else if (acc_valid) begin
            acc_q <= nxt.acc;
            n_q   <= nxt.neg;
            z_q   <= nxt.zero;
            v_q   <= v_q | nxt.ovf;
        end
    end

    // Output mapping.
    always_comb begin
        mac_hi = acc_q[ACC_W-1:LO_W];
        mac_lo = acc_q[LO_W-1:0];
        flag_n = n_q;
        flag_z = z_q;
        flag_v = v_q;
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mac_hi == '0 && mac_lo == '0 && !flag_v)); // R1
    AST_SAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sat_mode && !clr && !any_load)
        |=> (mac_hi == {HI_W{mac_lo[LO_W-1]}})); // R3
    AST_V_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v && !clr && !any_load) |=> flag_v); // R5
    AST_SAT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && sat_mode && !clr && !any_load)
        |=> (flag_z == (mac_lo == '0))); // R6
    AST_LOAD_CLR_V: assert property (@(posedge clk) disable iff (!rst_n)
        (any_load && !clr) |=> !flag_v); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !any_load && !acc_valid)
        |=> ($stable(mac_hi) && $stable(mac_lo) && $stable(flag_n)
             && $stable(flag_z) && $stable(flag_v))); // R13
endmodule

// File: tb/mac_sat_unit_tb.sv
module mac_sat_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n, sat_mode, clr, load_hi, load_lo, acc_valid;
    logic [31:0] load_data;
    logic [15:0] op_a, op_b;
    logic [9:0]  mac_hi;
    logic [31:0] mac_lo;
    logic        flag_n, flag_z, flag_v;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    longint m_acc;
    bit     m_n, m_z, m_v;

    localparam longint TWO41 = 64'sd1 <<< 41;
    localparam longint TWO42 = 64'sd1 <<< 42;

    always #5 clk = ~clk;

    mac_sat_unit u_dut (
        .clk(clk), .rst_n(rst_n), .sat_mode(sat_mode), .clr(clr),
        .load_hi(load_hi), .load_lo(load_lo), .load_data(load_data),
        .acc_valid(acc_valid), .op_a(op_a), .op_b(op_b),
        .mac_hi(mac_hi), .mac_lo(mac_lo),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
    );

    function automatic longint sx42(input longint x);
        longint y;
        y = x & (TWO42 - 1);
        if (((y >>> 41) & 1) != 0) y = y - TWO42;
        return y;
    endfunction

    // Behavioural reference for one clock edge.
    task automatic model_step();
        longint prod, sum, lo, hi;
        if (!rst_n) begin
            m_acc = 0; m_n = 0; m_z = 0; m_v = 0;
        end else if (clr) begin
            m_acc = 0; m_v = 0;
        end else if (load_hi || load_lo) begin
            lo = m_acc & 64'hFFFF_FFFF;
            hi = (m_acc >>> 32) & 64'h3FF;
            if (load_hi) hi = longint'(load_data) & 64'h3FF;
            if (load_lo) lo = longint'(load_data) & 64'hFFFF_FFFF;
            m_acc = sx42((hi <<< 32) | lo);
            m_v = 0;
        end else if (acc_valid) begin
            prod = longint'($signed(op_a)) * longint'($signed(op_b));
            sum  = m_acc + prod;
            if (sat_mode) begin
                if (sum > 64'sd2147483647) begin
                    sum = 64'sd2147483647; m_v = 1;
                end else if (sum < -64'sd2147483648) begin
                    sum = -64'sd2147483648; m_v = 1;
                end
                m_acc = sum;
                m_n = ((sum >>> 31) & 1) != 0;
                m_z = (sum & 64'hFFFF_FFFF) == 0;
            end else begin
                if (sum >= TWO41 || sum < -TWO41) m_v = 1;
                m_acc = sx42(sum);
                m_n = ((m_acc >>> 41) & 1) != 0;
                m_z = (m_acc == 0);
            end
        end
    endtask

    // One cycle: inputs already set; update model at the edge, compare after.
    task automatic cyc(input string tag);
        logic [9:0]  e_hi;
        logic [31:0] e_lo;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        e_hi = 10'((m_acc >>> 32) & 64'h3FF);
        e_lo = 32'(m_acc & 64'hFFFF_FFFF);
        checks++;
        if (mac_hi !== e_hi || mac_lo !== e_lo || flag_n !== m_n
            || flag_z !== m_z || flag_v !== m_v) begin
            errors++;
            $display("FAIL %s: got hi=%h lo=%h n=%b z=%b v=%b, expected hi=%h lo=%h n=%b z=%b v=%b",
                     tag, mac_hi, mac_lo, flag_n, flag_z, flag_v,
                     e_hi, e_lo, m_n, m_z, m_v);
        end
    endtask

    task automatic idle_in();
        clr = 0; load_hi = 0; load_lo = 0; acc_valid = 0;
    endtask

    task automatic do_acc(input logic sm, input int a, input int b, input string tag);
        idle_in(); sat_mode = sm; acc_valid = 1;
        op_a = 16'(a); op_b = 16'(b);
        cyc(tag);
    endtask

    task automatic do_load(input logic h, input logic l, input logic [31:0] d, input string tag);
        idle_in(); load_hi = h; load_lo = l; load_data = d;
        cyc(tag);
    endtask

    task automatic do_clr(input string tag);
        idle_in(); clr = 1;
        cyc(tag);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; sat_mode = 0; load_data = 32'hFFFF_FFFF;
        op_a = 16'h7FFF; op_b = 16'h7FFF;
        clr = 0; load_hi = 0; load_lo = 0; acc_valid = 1;
        m_acc = 0; m_n = 0; m_z = 0; m_v = 0;
        @(negedge clk);
        cyc("R12");                     // reset beats a pending accumulate
        cyc("R12");
        rst_n = 1;

        // R2 and R8 in wrapping mode
        do_acc(0, 3, 4, "R2");
        do_acc(0, -5, 7, "R8");
        do_acc(0, -32768, -32768, "R2");
        do_clr("R1");

        // R7: wrapping zero needs both halves zero
        do_acc(0, 0, 5, "R7");
        do_load(1, 1, 32'h0000_0001, "R10");   // hi=1, lo=1
        do_acc(0, -1, 1, "R7");                // lo becomes 0, hi 1 -> z=0
        // R6: saturating zero looks at low word only
        do_clr("R1");
        do_acc(1, 0, 0, "R6");

        // R3 positive clamp, then R5 sticky
        do_load(0, 1, 32'h7FFF_FFF0, "R10");
        do_acc(1, 100, 1, "R3");
        do_acc(1, -1, 1, "R5");
        // R9: mode change only
        idle_in(); sat_mode = 0; cyc("R9");
        idle_in(); sat_mode = 1; cyc("R9");
        // R3 negative clamp after load clears V
        do_load(1, 1, 32'h8000_0005, "R10");   // hi=0x005, lo=0x80000005
        do_load(1, 0, 32'hFFFF_FFFF, "R10");   // hi=0x3FF
        do_acc(1, -10, 1, "R3");
        do_acc(1, -32768, 32767, "R3");

        // R4 wrapping overflow at the 42-bit limit
        do_clr("R1");
        do_load(1, 1, 32'hFFFF_FFFF, "R10");
        do_load(1, 0, 32'h0000_01FF, "R10");   // acc = 2^41-1
        do_acc(0, 1, 1, "R4");
        do_acc(0, -1, 1, "R4");
        do_acc(0, 1, 1, "R5");
        do_load(0, 1, 32'h1234_5678, "R10");

        // R11 priority
        idle_in(); clr = 1; load_lo = 1; load_data = 32'h55; acc_valid = 1;
        op_a = 16'd9; op_b = 16'd9; cyc("R11");
        idle_in(); load_hi = 1; load_data = 32'h2A; acc_valid = 1; cyc("R11");

        // R13: inputs move without any command
        idle_in(); op_a = 16'h1234; op_b = 16'h8001; load_data = 32'hDEAD_BEEF; cyc("R13");
        idle_in(); op_a = 16'h7FFF; op_b = 16'h7FFF; cyc("R13");

        // Mixed random stream
        for (int i = 0; i < 2000; i++) begin
            int r;
            idle_in();
            r = $urandom % 12;
            if ($urandom % 8 == 0) sat_mode = ~sat_mode;
            case (r)
                0:       clr = 1;
                1:       load_hi = 1;
                2:       load_lo = 1;
                3:       ;
                default: acc_valid = 1;
            endcase
            load_data = $urandom;
            op_a = ($urandom % 3 == 0) ? 16'h8000 : 16'($urandom);
            op_b = ($urandom % 3 == 0) ? 16'h7FFF : 16'($urandom);
            cyc("R2");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule